// File: doc/BRIEF.md
# NAND Sector SEC-DED ECC Unit

This unit sits next to a NAND transfer sequencer and protects one 512-byte main sector plus its 16-byte spare area. The sequencer taps every byte it moves between the page buffer and the flash into the unit, tagged with its index and with a flag telling main from spare. During a program (data-input) transfer the unit accumulates a row/column parity code and, once the transfer ends, writes that code into five reserved spare bytes through the buffer write port.

During a page-output transfer the unit recomputes the code, captures the stored one as it streams past, and forms a syndrome for the main sector and one for the free spare bytes. A single flipped data bit is repaired in place through a read-modify-write on the buffer port. A flip inside the stored code is recognised and leaves the data alone. Anything else nonzero is reported as uncorrectable. A 4-bit status word with one 2-bit field per area becomes valid when the check finishes.

The enable input is sampled when a transfer starts. With it low, the unit neither reads nor writes the buffer, and a read reports a clean status.

Top module: `ecc_sector_unit`

## Requirements
- R1: After a program transfer with ECC enabled, spare bytes 6, 7 and 8 hold bits [23:0] of the code word, with byte 6+j = code[8j+7:8j]. Code bit k (k = 0..11) is the XOR of all main data bits whose bit address (byte_index*8 + bit) has bit k set. Code bit 12+k is the XOR of those whose address has bit k clear.
- R2: The same program transfer writes spare bytes 9 and 10 with code[39:24]. code[30:24] is the set-bit parity and code[37:31] is the clear-bit parity over the free spare bytes (0-5 and 11-15), each addressed as spare_index*8 + bit. code[39:38] is written as 0.
- R3: A program transfer writes only spare bytes 6 to 10. Main bytes and free spare bytes remain unchanged.
- R4: With ecc_en low at transfer start, the unit issues no buffer reads or writes. Spare code bytes pass unchanged, and a read ends with status 0 and status_valid 1, leaving any error in the buffer.
- R5: A read of an unaltered sector gives status 4'b0000 and modifies no buffer byte.
- R6: A single flipped main data bit at any byte (0 to 511) and bit is restored in the buffer. status[3:2] reads 2'b01.
- R7: A single flipped bit in stored main code bytes 6-8 leaves the buffer unmodified and gives status[3:2] = 2'b01.
- R8: Two flipped main data bits give status[3:2] = 2'b10, and the buffer is left with both flips.
- R9: A single flipped bit in a free spare byte is restored and gives status[1:0] = 2'b01. This is independent of the main field, so a simultaneous main and spare single error reads 4'b0101.
- R10: Starting a page-output transfer clears status to 0 and status_valid to 0 on the next cycle. status_valid rises when the check and any correction have finished, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | ECC enable, sampled at transfer start |
| xfer_start | input | 1 | One-cycle pulse starting a transfer (accepted when idle) |
| xfer_prog | input | 1 | With xfer_start: 1 = program (data-input), 0 = page-output |
| xfer_end | input | 1 | One-cycle pulse after the last tapped byte |
| tap_valid | input | 1 | Tapped byte valid this cycle |
| tap_spare | input | 1 | Tapped byte belongs to the spare area |
| tap_idx | input | 9 | Byte index within main sector or spare area |
| tap_data | input | 8 | Tapped byte value |
| buf_addr | output | 10 | Buffer byte address (spare at 512 + index) |
| buf_re | output | 1 | Buffer read request, data returned next cycle |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data (one cycle after buf_re) |
| busy | output | 1 | Transfer or check in progress |
| status | output | 4 | [3:2] main, [1:0] spare: 0 clean, 1 corrected, 2 uncorrectable |
| status_valid | output | 1 | Status holds the result of the last read |

## Verification
The bench flips data bits at the first and last main byte, at the lowest and highest bit positions. A wrong address split in the syndrome would then repair the wrong byte or bit and leave the original flip in place. It also flips a bit inside the stored code. A unit that did not separate a one-hot syndrome from a data syndrome would corrupt a healthy data byte and report the wrong field. Double flips confirm that nothing is written back and the main field reads 2. A combined main-and-spare single error catches fields that are swapped or merged. Runs with the enable low confirm that the code bytes survive a program transfer and that a read leaves a planted error alone.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_DATA = 2'd1,
    K_CODE = 2'd2,
    K_FAIL = 2'd3
  } ecc_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RUN, ST_CODE, ST_EVAL, ST_MRD, ST_MWR, ST_SRD, ST_SWR, ST_FIN
  } ecc_state_e;

  // Status field code for one area.
  function automatic logic [1:0] kind_field(ecc_kind_e k);
    case (k)
      K_NONE:  return 2'd0;
      K_FAIL:  return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  // Lanes of a byte whose bit position has bit k set.
  function automatic logic [7:0] lane_mask(int k);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> k) & 1) == 1;
    return m;
  endfunction

endpackage

// File: rtl/ecc_par_acc.sv
module ecc_par_acc
  import ecc_pkg::*;
#(
  parameter int IDX_W = 9,
  localparam int PW = IDX_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic [PW-1:0]    p_set,
  output logic [PW-1:0]    p_clr
);

  logic [PW-1:0] d_set, d_clr;
  logic          byte_par;

  assign byte_par = ^data;

  for (genvar gk = 0; gk < PW; gk++) begin : g_bit
    if (gk < 3) begin : g_lane
      assign d_set[gk] = ^(data &  lane_mask(gk));
      assign d_clr[gk] = ^(data & ~lane_mask(gk));
    end else begin : g_row
      assign d_set[gk] =  idx[gk-3] & byte_par;
      assign d_clr[gk] = ~idx[gk-3] & byte_par;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      p_set <= '0;
      p_clr <= '0;
    end else if (upd) begin
      p_set <= p_set ^ d_set;
      p_clr <= p_clr ^ d_clr;
    end
  end

endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import ecc_pkg::*;
#(
  parameter int PW = 12
) (
  input  logic [PW-1:0] calc_set,
  input  logic [PW-1:0] calc_clr,
  input  logic [PW-1:0] stor_set,
  input  logic [PW-1:0] stor_clr,
  output ecc_kind_e     kind,
  output logic [PW-1:0] loc
);

  logic [PW-1:0] e_set, e_clr;
  int            ones;

  assign e_set = calc_set ^ stor_set;
  assign e_clr = calc_clr ^ stor_clr;
  assign loc   = e_set;

  always_comb begin
    ones = $countones({e_set, e_clr});
    if (ones == 0)                          kind = K_NONE;
    else if (ones == 1)                     kind = K_CODE;
    else if ((e_set ^ e_clr) == {PW{1'b1}}) kind = K_DATA;
    else                                    kind = K_FAIL;
  end

endmodule

// File: rtl/ecc_sector_unit.sv
module ecc_sector_unit
  import ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SPARE_BYTES  = 16,
  parameter int CODE_POS     = 6,
  localparam int MAIN_AW     = $clog2(SECTOR_BYTES),
  localparam int SPARE_AW    = $clog2(SPARE_BYTES),
  localparam int BUF_AW      = $clog2(SECTOR_BYTES + SPARE_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ecc_en,
  input  logic               xfer_start,
  input  logic               xfer_prog,
  input  logic               xfer_end,
  input  logic               tap_valid,
  input  logic               tap_spare,
  input  logic [MAIN_AW-1:0] tap_idx,
  input  logic [7:0]         tap_data,
  output logic [BUF_AW-1:0]  buf_addr,
  output logic               buf_re,
  output logic               buf_we,
  output logic [7:0]         buf_wdata,
  input  logic [7:0]         buf_rdata,
  output logic               busy,
  output logic [3:0]         status,
  output logic               status_valid
);

  localparam int MPAR        = MAIN_AW + 3;
  localparam int SPAR        = SPARE_AW + 3;
  localparam int MCODE_BYTES = (2 * MPAR + 7) / 8;
  localparam int SCODE_BYTES = (2 * SPAR + 7) / 8;
  localparam int CODE_BYTES  = MCODE_BYTES + SCODE_BYTES;
  localparam int CODE_W      = 8 * CODE_BYTES;
  localparam int SOFF        = 8 * MCODE_BYTES;
  localparam int USED_W      = SOFF + 2 * SPAR;
  localparam int WCNT_W      = $clog2(CODE_BYTES + 1);
  localparam logic [SPARE_AW-1:0] CODE_LO = SPARE_AW'(CODE_POS);
  localparam logic [SPARE_AW-1:0] CODE_HI = SPARE_AW'(CODE_POS + CODE_BYTES - 1);
  localparam logic [BUF_AW-1:0]   SP_BASE = BUF_AW'(SECTOR_BYTES);
  localparam logic [BUF_AW-1:0]   CODE_BASE = BUF_AW'(SECTOR_BYTES + CODE_POS);

  ecc_state_e          st;
  logic                prog_q, en_q;
  logic [WCNT_W-1:0]   wcnt;
  logic [CODE_W-1:0]   stored, code_calc;
  logic [MPAR-1:0]     mp_set, mp_clr, m_loc, ml;
  logic [SPAR-1:0]     sp_set, sp_clr, s_loc, sl;
  ecc_kind_e           m_kind, s_kind, mk, sk;
  logic [SPARE_AW-1:0] sp_idx;
  logic                in_code, start_ok, upd_m, upd_s;
  logic [BUF_AW-1:0]   m_addr, s_addr;
  logic                unused_pad;

  assign sp_idx   = tap_idx[SPARE_AW-1:0];
  assign in_code  = (sp_idx >= CODE_LO) && (sp_idx <= CODE_HI);
  assign start_ok = (st == ST_IDLE) && xfer_start;
  assign upd_m    = (st == ST_RUN) && tap_valid && !tap_spare;
  assign upd_s    = (st == ST_RUN) && tap_valid && tap_spare && !in_code;
  assign busy     = (st != ST_IDLE);

  ecc_par_acc #(.IDX_W(MAIN_AW)) u_acc_main (
    .clk(clk), .rst(rst), .clr(start_ok), .upd(upd_m),
    .idx(tap_idx), .data(tap_data), .p_set(mp_set), .p_clr(mp_clr)
  );

  ecc_par_acc #(.IDX_W(SPARE_AW)) u_acc_spare (
    .clk(clk), .rst(rst), .clr(start_ok), .upd(upd_s),
    .idx(sp_idx), .data(tap_data), .p_set(sp_set), .p_clr(sp_clr)
  );

  always_comb begin
    code_calc = '0;
    code_calc[0 +: MPAR]           = mp_set;
    code_calc[MPAR +: MPAR]        = mp_clr;
    code_calc[SOFF +: SPAR]        = sp_set;
    code_calc[SOFF + SPAR +: SPAR] = sp_clr;
  end

  assign unused_pad = ^stored[CODE_W-1:USED_W];

  ecc_syndrome #(.PW(MPAR)) u_syn_main (
    .calc_set(mp_set), .calc_clr(mp_clr),
    .stor_set(stored[0 +: MPAR]), .stor_clr(stored[MPAR +: MPAR]),
    .kind(mk), .loc(ml)
  );

  ecc_syndrome #(.PW(SPAR)) u_syn_spare (
    .calc_set(sp_set), .calc_clr(sp_clr),
    .stor_set(stored[SOFF +: SPAR]), .stor_clr(stored[SOFF + SPAR +: SPAR]),
    .kind(sk), .loc(sl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      prog_q       <= 1'b0;
      en_q         <= 1'b0;
      wcnt         <= '0;
      stored       <= '0;
      m_kind       <= K_NONE;
      s_kind       <= K_NONE;
      m_loc        <= '0;
      s_loc        <= '0;
      status       <= '0;
      status_valid <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (xfer_start) begin
          prog_q <= xfer_prog;
          en_q   <= ecc_en;
          wcnt   <= '0;
          stored <= '0;
          m_kind <= K_NONE;
          s_kind <= K_NONE;
          st     <= ST_RUN;
          if (!xfer_prog) begin
            status       <= '0;
            status_valid <= 1'b0;
          end
        end
        ST_RUN: begin
          if (tap_valid && tap_spare && !prog_q) begin
            for (int j = 0; j < CODE_BYTES; j++)
              if (sp_idx == SPARE_AW'(CODE_POS + j)) stored[8*j +: 8] <= tap_data;
          end
          if (xfer_end) begin
            if (prog_q) st <= en_q ? ST_CODE : ST_IDLE;
            else        st <= en_q ? ST_EVAL : ST_FIN;
          end
        end
        ST_CODE: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WCNT_W'(CODE_BYTES - 1)) st <= ST_IDLE;
        end
        ST_EVAL: begin
          m_kind <= mk;
          m_loc  <= ml;
          s_loc  <= sl;
          if (sk == K_DATA && sl[SPAR-1:3] >= CODE_LO && sl[SPAR-1:3] <= CODE_HI)
            s_kind <= K_FAIL;
          else
            s_kind <= sk;
          st <= ST_MRD;
        end
        ST_MRD: st <= ST_MWR;
        ST_MWR: st <= ST_SRD;
        ST_SRD: st <= ST_SWR;
        ST_SWR: st <= ST_FIN;
        ST_FIN: begin
          status       <= {kind_field(m_kind), kind_field(s_kind)};
          status_valid <= 1'b1;
          st           <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign m_addr = BUF_AW'(m_loc[MPAR-1:3]);
  assign s_addr = SP_BASE + BUF_AW'(s_loc[SPAR-1:3]);

  always_comb begin
    buf_re    = 1'b0;
    buf_we    = 1'b0;
    buf_addr  = '0;
    buf_wdata = '0;
    case (st)
      ST_CODE: begin
        buf_we    = 1'b1;
        buf_addr  = CODE_BASE + BUF_AW'(wcnt);
        buf_wdata = code_calc[{wcnt, 3'b000} +: 8];
      end
      ST_MRD: if (m_kind == K_DATA) begin
        buf_re   = 1'b1;
        buf_addr = m_addr;
      end
      ST_MWR: if (m_kind == K_DATA) begin
        buf_we    = 1'b1;
        buf_addr  = m_addr;
        buf_wdata = buf_rdata ^ (8'd1 << m_loc[2:0]);
      end
      ST_SRD: if (s_kind == K_DATA) begin
        buf_re   = 1'b1;
        buf_addr = s_addr;
      end
      ST_SWR: if (s_kind == K_DATA) begin
        buf_we    = 1'b1;
        buf_addr  = s_addr;
        buf_wdata = buf_rdata ^ (8'd1 << s_loc[2:0]);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ecc_sector_chk.sv
module ecc_sector_chk #(
  parameter int BUF_AW   = 10,
  parameter int CODE_LO  = 518,
  parameter int CODE_HI  = 522
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_start,
  input logic              xfer_prog,
  input logic              busy,
  input logic              prog_q,
  input logic              en_q,
  input logic              buf_re,
  input logic              buf_we,
  input logic [BUF_AW-1:0] buf_addr,
  input logic [3:0]        status,
  input logic              status_valid
);

  localparam logic [BUF_AW-1:0] LO = BUF_AW'(CODE_LO);
  localparam logic [BUF_AW-1:0] HI = BUF_AW'(CODE_HI);

  // R3: program transfers touch only the code slots
  a_r3_prog_write_slots: assert property (@(posedge clk) disable iff (rst)
    (busy && prog_q && buf_we) |-> (buf_addr >= LO && buf_addr <= HI));

  // R3: program transfers never read the buffer
  a_r3_prog_no_read: assert property (@(posedge clk) disable iff (rst)
    (busy && prog_q) |-> !buf_re);

  // R4: disabled transfers stay off the buffer port
  a_r4_off_no_access: assert property (@(posedge clk) disable iff (rst)
    (busy && !en_q) |-> (!buf_we && !buf_re));

  // R6: a correction write follows a read of the same byte
  a_r6_fix_after_read: assert property (@(posedge clk) disable iff (rst)
    (buf_we && !prog_q) |-> ($past(buf_re) && $stable(buf_addr)));

  // R8: status fields hold only legal codes
  a_r8_field_legal: assert property (@(posedge clk) disable iff (rst)
    status_valid |-> (status[3:2] != 2'b11 && status[1:0] != 2'b11));

  // R10: a read start clears the result
  a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
    (xfer_start && !xfer_prog && !busy) |=> (!status_valid && status == 4'b0000));

endmodule

bind ecc_sector_unit ecc_sector_chk #(
  .BUF_AW (BUF_AW),
  .CODE_LO(SECTOR_BYTES + CODE_POS),
  .CODE_HI(SECTOR_BYTES + CODE_POS + CODE_BYTES - 1)
) u_chk (
  .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_prog(xfer_prog),
  .busy(busy), .prog_q(prog_q), .en_q(en_q), .buf_re(buf_re), .buf_we(buf_we),
  .buf_addr(buf_addr), .status(status), .status_valid(status_valid)
);

// File: tb/test_ecc_sector_unit.sv
module test_ecc_sector_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ecc_en = 1'b1;
  logic       xfer_start = 1'b0, xfer_prog = 1'b0, xfer_end = 1'b0;
  logic       tap_valid = 1'b0, tap_spare = 1'b0;
  logic [8:0] tap_idx = '0;
  logic [7:0] tap_data = '0;
  logic [9:0] buf_addr;
  logic       buf_re, buf_we, busy, status_valid;
  logic [7:0] buf_wdata;
  logic [7:0] buf_rdata = '0;
  logic [3:0] status;

  logic [7:0] mem [0:527];
  logic [7:0] snap [0:527];
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ecc_sector_unit i_ecc_sector_unit (
    .clk(clk), .rst(rst), .ecc_en(ecc_en), .xfer_start(xfer_start),
    .xfer_prog(xfer_prog), .xfer_end(xfer_end), .tap_valid(tap_valid),
    .tap_spare(tap_spare), .tap_idx(tap_idx), .tap_data(tap_data),
    .buf_addr(buf_addr), .buf_re(buf_re), .buf_we(buf_we),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .busy(busy),
    .status(status), .status_valid(status_valid)
  );

  always @(posedge clk) begin
    if (buf_we) mem[buf_addr] <= buf_wdata;
    if (buf_re) buf_rdata <= mem[buf_addr];
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] calc_code();
    logic [11:0] p1 = '0, p0 = '0, a;
    logic [6:0]  q1 = '0, q0 = '0, s;
    for (int i = 0; i < 512; i++)
      for (int b = 0; b < 8; b++)
        if (mem[i][b]) begin
          a = 12'(i * 8 + b);
          for (int k = 0; k < 12; k++)
            if (a[k]) p1[k] = ~p1[k]; else p0[k] = ~p0[k];
        end
    for (int i = 0; i < 16; i++)
      if (i < 6 || i > 10)
        for (int b = 0; b < 8; b++)
          if (mem[512 + i][b]) begin
            s = 7'(i * 8 + b);
            for (int k = 0; k < 7; k++)
              if (s[k]) q1[k] = ~q1[k]; else q0[k] = ~q0[k];
          end
    return {2'b00, q0, q1, p0, p1};
  endfunction

  task automatic take_snap();
    for (int i = 0; i < 528; i++) snap[i] = mem[i];
  endtask

  function automatic int diff_count();
    int n = 0;
    for (int i = 0; i < 528; i++) if (mem[i] !== snap[i]) n++;
    return n;
  endfunction

  task automatic run_xfer(bit prog);
    @(negedge clk);
    xfer_start = 1'b1;
    xfer_prog  = prog;
    @(negedge clk);
    xfer_start = 1'b0;
    if (!prog) begin
      check("R10 valid cleared at start", {63'd0, status_valid}, 64'd0);
      check("R10 status cleared at start", {60'd0, status}, 64'd0);
    end
    for (int i = 0; i < 528; i++) begin
      tap_valid = 1'b1;
      tap_spare = (i >= 512);
      tap_idx   = (i >= 512) ? 9'(i - 512) : 9'(i);
      tap_data  = mem[i];
      @(negedge clk);
    end
    tap_valid = 1'b0;
    xfer_end  = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    for (int w = 0; w < 50 && busy; w++) @(negedge clk);
    check("R10 unit returns idle", {63'd0, busy}, 64'd0);
  endtask

  task automatic fill(int seed);
    for (int i = 0; i < 528; i++) mem[i] = 8'((i * seed + (i >> 3) * 29 + seed * 7) ^ (i >> 1));
    for (int j = 518; j < 523; j++) mem[j] = 8'h5A;
  endtask

  task automatic t_program(int seed);
    logic [39:0] exp;
    fill(seed);
    exp = calc_code();
    take_snap();
    run_xfer(1'b1);
    for (int j = 0; j < 3; j++) check("R1 main code byte", {56'd0, mem[518 + j]}, {56'd0, exp[8*j +: 8]});
    for (int j = 3; j < 5; j++) check("R2 spare code byte", {56'd0, mem[518 + j]}, {56'd0, exp[8*j +: 8]});
    for (int j = 518; j < 523; j++) snap[j] = mem[j];
    check("R3 other bytes untouched", 64'(diff_count()), 64'd0);
  endtask

  task automatic t_clean();
    take_snap();
    run_xfer(1'b0);
    check("R5 clean status", {59'd0, status_valid, status}, {59'd0, 1'b1, 4'b0000});
    check("R5 buffer unchanged", 64'(diff_count()), 64'd0);
  endtask

  task automatic t_main_single(int byt, int bitn);
    take_snap();
    mem[byt][bitn] = ~mem[byt][bitn];
    run_xfer(1'b0);
    check("R6 main bit restored", 64'(diff_count()), 64'd0);
    check("R6 main corrected status", {59'd0, status_valid, status}, {59'd0, 1'b1, 4'b0100});
  endtask

  task automatic t_code_err();
    take_snap();
    mem[519] ^= 8'h04;
    run_xfer(1'b0);
    check("R7 code byte left as read", {56'd0, mem[519]}, {56'd0, snap[519] ^ 8'h04});
    snap[519] ^= 8'h04;
    check("R7 no other change", 64'(diff_count()), 64'd0);
    check("R7 status main corrected", {59'd0, status_valid, status}, {59'd0, 1'b1, 4'b0100});
    mem[519] ^= 8'h04;
  endtask

  task automatic t_double();
    take_snap();
    mem[10] ^= 8'h02;
    mem[400] ^= 8'h40;
    run_xfer(1'b0);
    check("R8 uncorrectable status", {59'd0, status_valid, status}, {59'd0, 1'b1, 4'b1000});
    check("R8 both flips remain", 64'(diff_count()), 64'd2);
    mem[10] ^= 8'h02;
    mem[400] ^= 8'h40;
  endtask

  task automatic t_spare_single();
    take_snap();
    mem[525] ^= 8'h04;
    run_xfer(1'b0);
    check("R9 spare bit restored", 64'(diff_count()), 64'd0);
    check("R9 spare corrected status", {59'd0, status_valid, status}, {59'd0, 1'b1, 4'b0001});
  endtask

  task automatic t_both();
    take_snap();
    mem[77] ^= 8'h10;
    mem[512] ^= 8'h80;
    run_xfer(1'b0);
    check("R9 R6 both restored", 64'(diff_count()), 64'd0);
    check("R9 independent fields", {59'd0, status_valid, status}, {59'd0, 1'b1, 4'b0101});
  endtask

  task automatic t_disabled();
    ecc_en = 1'b0;
    for (int j = 518; j < 523; j++) mem[j] = 8'hEE;
    take_snap();
    run_xfer(1'b1);
    check("R4 code bytes pass unchanged", 64'(diff_count()), 64'd0);
    mem[100] ^= 8'h01;
    take_snap();
    run_xfer(1'b0);
    check("R4 disabled read status", {59'd0, status_valid, status}, {59'd0, 1'b1, 4'b0000});
    check("R4 error left in buffer", 64'(diff_count()), 64'd0);
    ecc_en = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 528; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset state", {58'd0, busy, status_valid, status}, 64'd0);
    t_program(3);
    t_clean();
    t_main_single(0, 0);
    t_main_single(511, 7);
    t_main_single(300, 5);
    t_code_err();
    t_double();
    t_clean();
    t_spare_single();
    t_both();
    t_program(11);
    t_clean();
    t_disabled();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule